// File: doc/BRIEF.md
# Aging-Counter Page Replacement Unit

This block tracks recent use of a set of page frames and names the frame that is the best candidate for eviction. Each frame keeps an 8-bit history register and a single "touched" flag. Any access to a frame raises its flag. When the periodic interval strobe arrives, every history register moves one place toward its low end and takes the frame's flag into its top bit. All flags are then cleared, so older activity carries less weight with every interval. The result approximates least-recently-used ordering with a fixed cost per frame.

A combinational minimum-finder tree compares all history values. The winner's index and value are captured in a register and driven on the victim outputs. When a new page is brought into a frame, the unit is told with a load strobe. That frame's history restarts at zero and its flag is raised, so the fresh page is credited at the next interval. The interval timer and the page-table storage sit outside the block.

Top module: `aging_lru`

## Requirements
- R1: While reset is asserted and after its release, every history register and flag is zero, and the outputs read victim_page = 0 and victim_age = 0.
- R2: An access (acc_valid high with acc_page = p) raises the flag of frame p. At the next interval strobe, the top bit (bit 7) of frame p's history becomes 1.
- R3: On an interval strobe, each frame's history becomes {flag, history[7:1]}. For example, flag 1 with history 0x04 gives 0x82.
- R4: Every flag is cleared once the interval strobe has sampled it. A frame not touched in the next interval therefore gets a 0 at bit 7 on the following strobe.
- R5: An access in the same cycle as the interval strobe is not used by that strobe. It sets the flag for the following interval instead.
- R6: victim_age equals the smallest history value over all frames, and victim_page is a frame that holds that value.
- R7: When several frames share the smallest value, victim_page is the lowest frame index among them.
- R8: A load (load_valid high with load_page = p) sets frame p's history to 0x00 and raises its flag. A load takes priority over a strobe for that frame in the same cycle.
- R9: The victim outputs are registered. A change of history made at clock edge k appears on victim_page and victim_age after clock edge k+1.
- R10: Accesses without an interval strobe leave all history values, and so the victim outputs, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Interval strobe: shift flags into histories, then clear flags |
| acc_valid | input | 1 | A frame is accessed this cycle |
| acc_page | input | $clog2(NPAGES) | Index of the accessed frame |
| load_valid | input | 1 | A new page is placed in a frame this cycle |
| load_page | input | $clog2(NPAGES) | Index of the frame being loaded |
| victim_page | output | $clog2(NPAGES) | Registered index of the least-used frame |
| victim_age | output | CW | Registered history value of that frame |

## Verification
A corrupted history register or a stuck flag reaches the ports only through the victim outputs. The fault shows one cycle after the state change, but only once the damaged frame becomes the minimum or should have been it. The bench therefore steers chosen frames into the minimum position on purpose: for a frame left untouched, a frame touched in the strobe cycle, and a freshly loaded frame. A long pseudo-random run then compares every cycle's victim against an arithmetic model. In that run, shift, clear and tie-break faults surface within a few intervals.

// File: rtl/aging_lru.sv
module aging_lru #(
  parameter int NPAGES = 8,
  parameter int CW     = 8,
  localparam int IW    = (NPAGES > 1) ? $clog2(NPAGES) : 1,
  localparam int P2    = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_page,
  input  logic          load_valid,
  input  logic [IW-1:0] load_page,
  output logic [IW-1:0] victim_page,
  output logic [CW-1:0] victim_age
);

  logic [NPAGES-1:0][CW-1:0] cnt;
  logic [NPAGES-1:0]         refb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      refb <= '0;
    end else begin
      for (int i = 0; i < NPAGES; i++) begin
        if (load_valid && load_page == IW'(i)) begin
          cnt[i]  <= '0;
          refb[i] <= 1'b1;
        end else begin
          if (tick) cnt[i] <= {refb[i], cnt[i][CW-1:1]};
          refb[i] <= (acc_valid && acc_page == IW'(i)) | (refb[i] & ~tick);
        end
      end
    end
  end

  logic [2*P2-2:0][CW:0]   nval;
  logic [2*P2-2:0][IW-1:0] nidx;

  for (genvar j = 0; j < P2; j++) begin : g_leaf
    if (j < NPAGES) begin : g_real
      assign nval[P2-1+j] = {1'b0, cnt[j]};
    end else begin : g_pad
      assign nval[P2-1+j] = {1'b1, {CW{1'b0}}};
    end
    assign nidx[P2-1+j] = IW'(j);
  end

  for (genvar k = 0; k < P2-1; k++) begin : g_node
    logic take_r;
    assign take_r  = nval[2*k+2] < nval[2*k+1];
    assign nval[k] = take_r ? nval[2*k+2] : nval[2*k+1];
    assign nidx[k] = take_r ? nidx[2*k+2] : nidx[2*k+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_page <= '0;
      victim_age  <= '0;
    end else begin
      victim_page <= nidx[0];
      victim_age  <= nval[0][CW-1:0];
    end
  end

endmodule

// File: rtl/aging_lru_chk.sv
module aging_lru_chk #(
  parameter int NPAGES = 8,
  parameter int CW     = 8,
  localparam int IW    = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      acc_valid,
  input logic [IW-1:0]             acc_page,
  input logic                      load_valid,
  input logic [IW-1:0]             load_page,
  input logic [NPAGES-1:0][CW-1:0] cnt,
  input logic [NPAGES-1:0]         refb,
  input logic [IW-1:0]             victim_page,
  input logic [CW-1:0]             victim_age
);

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (victim_page == '0 && victim_age == '0));

  for (genvar i = 0; i < NPAGES; i++) begin : g_pg
    // R2
    acc_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_page == IW'(i)) |=> refb[i]);
    // R3
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(load_valid && load_page == IW'(i)))
        |=> cnt[i] == {$past(refb[i]), $past(cnt[i][CW-1:1])});
    // R8
    load_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && load_page == IW'(i)) |=> (cnt[i] == '0 && refb[i]));
    // R6
    min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> victim_age <= $past(cnt[i]));
    // R9
    victim_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (victim_page == IW'(i)) |-> victim_age == $past(cnt[i]));
  end

endmodule

bind aging_lru aging_lru_chk #(.NPAGES(NPAGES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .acc_valid(acc_valid), .acc_page(acc_page),
  .load_valid(load_valid), .load_page(load_page),
  .cnt(cnt), .refb(refb),
  .victim_page(victim_page), .victim_age(victim_age)
);

// File: tb/aging_lru_tb.sv
module aging_lru_tb;
  localparam int N  = 8;
  localparam int CW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, acc_valid = 1'b0, load_valid = 1'b0;
  logic [IW-1:0] acc_page = '0, load_page = '0;
  logic [IW-1:0] victim_page;
  logic [CW-1:0] victim_age;

  int total = 0, bad = 0;
  logic [CW-1:0] m_cnt [N];
  logic          m_ref [N];
  logic [31:0]   lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  aging_lru #(.NPAGES(N), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .acc_valid(acc_valid), .acc_page(acc_page),
    .load_valid(load_valid), .load_page(load_page),
    .victim_page(victim_page), .victim_age(victim_age)
  );

  task automatic expect_v(input string req, input int ep, input int ea);
    total++;
    if (victim_page != IW'(ep) || victim_age != CW'(ea)) begin
      bad++;
      $display("FAIL %s: victim page=%0d age=%02h, expected page=%0d age=%02h",
               req, victim_page, victim_age, ep, ea);
    end
  endtask

  task automatic cyc(input logic t, input logic av, input int ap,
                     input logic lv, input int lp);
    @(negedge clk);
    tick = t; acc_valid = av; acc_page = IW'(ap);
    load_valid = lv; load_page = IW'(lp);
    @(negedge clk);
    tick = 1'b0; acc_valid = 1'b0; load_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lv && lp == i) begin
        m_cnt[i] = '0; m_ref[i] = 1'b1;
      end else begin
        if (t) m_cnt[i] = {m_ref[i], m_cnt[i][CW-1:1]};
        m_ref[i] = (av && ap == i) | (m_ref[i] & ~t);
      end
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic touch_all_but(input int a, input int b);
    for (int p = 0; p < N; p++)
      if (p != a && p != b) cyc(1'b0, 1'b1, p, 1'b0, 0);
  endtask

  task automatic model_check(input string req);
    int bp; int ba;
    bp = 0; ba = int'(m_cnt[0]);
    for (int i = 1; i < N; i++)
      if (int'(m_cnt[i]) < ba) begin bp = i; ba = int'(m_cnt[i]); end
    expect_v(req, bp, ba);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_ref[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_v("R1", 0, 8'h00);

    touch_all_but(2, 5);
    settle();
    expect_v("R10", 0, 8'h00);
    cyc(1'b1, 1'b0, 0, 1'b0, 0);
    settle();
    expect_v("R7 R2", 2, 8'h00);

    touch_all_but(6, 6);
    cyc(1'b1, 1'b0, 0, 1'b0, 0);
    settle();
    expect_v("R3 R4", 6, 8'h40);

    touch_all_but(6, 6);
    cyc(1'b1, 1'b1, 6, 1'b0, 0);
    settle();
    expect_v("R5 strobe", 6, 8'h20);
    cyc(1'b1, 1'b0, 0, 1'b0, 0);
    settle();
    expect_v("R5 next", 2, 8'h60);

    cyc(1'b0, 1'b0, 0, 1'b1, 1);
    expect_v("R9", 2, 8'h60);
    settle();
    expect_v("R8 load", 1, 8'h00);
    cyc(1'b1, 1'b0, 0, 1'b0, 0);
    settle();
    expect_v("R8 flag", 2, 8'h30);

    model_check("R6 directed");

    for (int s = 0; s < 600; s++) begin
      logic t; logic av; logic lv;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      t  = (lcg[17:16] == 2'b00);
      av = lcg[20];
      lv = (lcg[27:24] == 4'h0);
      cyc(t, av, int'(lcg[23:21]), lv, int'(lcg[30:28]));
      settle();
      model_check("R6 sweep");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule